// File: doc/BRIEF.md
# Addressed SPI Slave Control Port

This block is a serial slave port that moves byte messages between an external host and an internal processor. The host opens a transaction by pulling chip select low. The first byte it shifts in carries a 7-bit device address and a direction flag. When the address is accepted, a write transaction hands every further byte to the internal side as a one-cycle strobe. A read transaction shifts bytes out of the internal outbound queue instead.

An active-low request output tells the host that outbound bytes are waiting. During a read, the port samples the queue state at one fixed bit of each byte. It then keeps the request line at that value until the byte is finished, so the host knows early whether to fetch another byte.

Serial clock, chip select and data-in are synchronised into the system clock domain, and all work is done on detected edges there. The system clock must run at least four times faster than the serial clock.

Top module: `spi_ctrl_port`

## Requirements
- R1: The first byte after chip select falls is the header. Its bits [7:1] are the 7-bit address, sent MSB first. Its bit [0] is the direction flag: 1 selects read and 0 selects write.
- R2: With `cfg_chk_en`=1, a header whose address differs from `cfg_addr` makes the port ignore the rest of the transaction. No `rx_valid` pulse is produced, no `tx_pop` is produced and `spi_miso` stays 0. Changing `cfg_addr` moves the accepted address. The integrator ties `cfg_addr` to 0000000b by default.
- R3: With `cfg_chk_en`=0, every header address is accepted.
- R4: Bits travel MSB first. `spi_mosi` is sampled on the rising edge of `spi_sclk`, and `spi_miso` changes only after falling edges.
- R5: A write data byte appears on `rx_data` with a one-cycle `rx_valid` pulse only after the falling edge of its eighth serial clock. If chip select rises before that falling edge, the byte is dropped.
- R6: Any number of write data bytes may follow one header, and each one produces exactly one `rx_valid` pulse, in order.
- R7: In an accepted read, the head of the queue is loaded into the output shifter at the eighth falling edge of the header byte, and again at the eighth falling edge of each data byte. Every load from a non-empty queue gives exactly one `tx_pop` cycle.
- R8: `spi_req_n` is 1 after reset. Outside the data phase of an accepted read, `spi_req_n` is 0 exactly while `tx_avail` is 1.
- R9: In the data phase of a read, `spi_req_n` is updated only right after the seventh rising edge of each byte. It goes to 1 if the queue is empty at that edge and to 0 otherwise, and it holds that value until the next such edge.
- R10: A read byte loaded while the queue is empty is shifted out as 0x00 and does not pop the queue.
- R11: Chip select going high clears the bit counter and the header state, and a partial byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | 7 | Address the port answers to |
| cfg_chk_en | input | 1 | 1 = compare the header address, 0 = accept any |
| spi_csn | input | 1 | Active-low chip select from host |
| spi_sclk | input | 1 | Serial clock from host (idle low) |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_req_n | output | 1 | Active-low request: outbound data waiting |
| rx_data | output | 8 | Received write byte |
| rx_valid | output | 1 | One-cycle strobe qualifying rx_data |
| tx_data | input | 8 | Head of the outbound queue |
| tx_avail | input | 1 | Outbound queue is non-empty |
| tx_pop | output | 1 | One-cycle pop of the outbound queue head |

## Verification
The hardest situations to reach from the ports are those that depend on a single serial edge inside a byte. One is the request line decision at the seventh rising edge, which must read low on every byte while the queue still holds data and go high on the byte that drains it. The other is a byte whose eighth rising edge arrives but whose eighth falling edge never comes. To reach them, the bench drives the serial lines bit by bit. It can cut a byte after any number of bits or leave out the last falling edge, and it samples the request line between the seventh rising and falling edges. A bench-side queue model answers `tx_pop`, so the draining byte and the empty-queue reads are reached with known queue contents.

// File: rtl/spi_ctrl_pkg.sv
// Package: shared types for the addressed SPI control port.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_ctrl_pkg;

    // Transaction phase after chip select falls.
    typedef enum logic [1:0] {
        PH_HDR   = 2'd0,   // receiving the address/direction byte
        PH_WRITE = 2'd1,   // accepted write: bytes go to the internal side
        PH_READ  = 2'd2,   // accepted read: bytes come from the queue
        PH_SKIP  = 2'd3    // address mismatch: ignore until chip select rises
    } xfer_phase_t;

endpackage

// File: rtl/spi_sync_bit.sv
// Module: multi-stage synchroniser for one asynchronous input bit.
// Assumes: input changes no faster than every two system clocks; the
// reset value is the idle level of the line.
module spi_sync_bit #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_edge_sync.sv
// Module: synchronises chip select, serial clock and data-in, and detects
// serial clock edges while chip select is active.
// Assumes: system clock at least 4x the serial clock; chip select and data-in
// are stable around the serial clock edges that matter to them.
module spi_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_csn,
    input  logic spi_sclk,
    input  logic spi_mosi,
    output logic sel,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s
);

    localparam int         NUM_LINES = 3;
    localparam logic [2:0] IDLE_VAL  = 3'b001;   // {mosi, sclk, csn}

    logic [NUM_LINES-1:0] raw;
    logic [NUM_LINES-1:0] synced;
    logic                 sclk_prev;

    assign raw = {spi_mosi, spi_sclk, spi_csn};

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_sync
            spi_sync_bit #(
                .STAGES  (SYNC_STAGES),
                .RST_VAL (IDLE_VAL[i])
            ) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (raw[i]),
                .q     (synced[i])
            );
        end
    endgenerate

    // Remember the previous synchronised serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= synced[1];
        end
    end

    assign sel       = ~synced[0];
    assign sclk_rise = sel &  synced[1] & ~sclk_prev;
    assign sclk_fall = sel & ~synced[1] &  sclk_prev;
    assign mosi_s    = synced[2];

endmodule

// File: rtl/spi_rx_frame.sv
// Module: bit counting, receive shifting, header decode with address compare,
// and write-byte delivery.
// Assumes: edge strobes come from spi_edge_sync and are qualified by sel.
module spi_rx_frame
    import spi_ctrl_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_chk_en,
    output logic [ADDR_W:0]   rx_data,
    output logic              rx_valid,
    output xfer_phase_t       phase,
    output logic              byte_end,
    output logic              pre_last_rise,
    output logic              rd_load
);

    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              addr_hit;
    logic              hdr_read;

    assign byte_end      = sclk_fall && (bit_cnt == CNT_W'(BYTE_W));
    assign pre_last_rise = sclk_rise && (bit_cnt == CNT_W'(BYTE_W - 2));
    assign addr_hit      = !cfg_chk_en || (shreg[BYTE_W-1:1] == cfg_addr);
    assign hdr_read      = shreg[0];
    assign rd_load       = byte_end &&
                           ((phase == PH_READ) ||
                            (phase == PH_HDR && addr_hit && hdr_read));

    // Count serial bits and shift in data on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (sclk_rise) begin
            shreg   <= {shreg[BYTE_W-2:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
        end else if (byte_end) begin
            bit_cnt <= '0;
        end
    end

    // Decode the header byte and move the transaction phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            phase <= PH_HDR;
        end else if (byte_end && phase == PH_HDR) begin
            if (!addr_hit) begin
                phase <= PH_SKIP;
            end else if (hdr_read) begin
                phase <= PH_READ;
            end else begin
                phase <= PH_WRITE;
            end
        end
    end

    // Present each completed write byte with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= byte_end && (phase == PH_WRITE);
            if (byte_end && phase == PH_WRITE) begin
                rx_data <= shreg;
            end
        end
    end

    // The bit counter never passes one full byte.
    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(BYTE_W));

    // Releasing chip select clears the counter and header state.
    assert_release_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (bit_cnt == '0) && (phase == PH_HDR));

    // A write strobe only follows a byte taken in an accepted write phase.
    assert_strobe_in_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(phase == PH_WRITE));

endmodule

// File: rtl/spi_tx_path.sv
// Module: output shifter, queue pop and request line control.
// Assumes: the queue presents its head on tx_data with tx_avail, and removes
// that head on the clock edge where tx_pop is high.
module spi_tx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rd_active,
    input  logic              sclk_fall,
    input  logic              rd_load,
    input  logic              pre_last_rise,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_avail,
    output logic              tx_pop,
    output logic              spi_miso,
    output logic              spi_req_n
);

    logic [DATA_W-1:0] out_sh;
    logic              req_q;
    logic              shift_now;

    assign tx_pop    = rd_load && tx_avail;
    assign shift_now = rd_active && sclk_fall && !rd_load;

    // Load a fresh byte at the end of each byte, else shift on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            out_sh <= '0;
        end else if (rd_load) begin
            out_sh <= tx_avail ? tx_data : '0;
        end else if (shift_now) begin
            out_sh <= {out_sh[DATA_W-2:0], 1'b0};
        end
    end

    // Track queue state, freezing it between decision points in a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b1;
        end else if (!rd_active || pre_last_rise) begin
            req_q <= ~tx_avail;
        end
    end

    assign spi_miso  = out_sh[DATA_W-1];
    assign spi_req_n = req_q;

    // Inside a read, the request line moves only after the decision edge.
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active && !pre_last_rise |=> $stable(req_q));

    // With chip select released the output shifter is cleared.
    assert_idle_miso_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (out_sh == '0));

endmodule

// File: rtl/spi_ctrl_port.sv
// Module: top of the addressed SPI slave control port.
// Assumes: serial clock idles low, host samples data-out on rising edges,
// and the system clock is at least 4x the serial clock.
module spi_ctrl_port
    import spi_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_chk_en,
    input  logic              spi_csn,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_req_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_avail,
    output logic              tx_pop
);

    logic        sel;
    logic        sclk_rise;
    logic        sclk_fall;
    logic        mosi_s;
    xfer_phase_t phase;
    logic        byte_end;
    logic        pre_last_rise;
    logic        rd_load;

    spi_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_csn   (spi_csn),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .sel       (sel),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s)
    );

    spi_rx_frame #(
        .ADDR_W (ADDR_W)
    ) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel           (sel),
        .sclk_rise     (sclk_rise),
        .sclk_fall     (sclk_fall),
        .mosi_s        (mosi_s),
        .cfg_addr      (cfg_addr),
        .cfg_chk_en    (cfg_chk_en),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .phase         (phase),
        .byte_end      (byte_end),
        .pre_last_rise (pre_last_rise),
        .rd_load       (rd_load)
    );

    spi_tx_path #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel           (sel),
        .rd_active     (phase == PH_READ),
        .sclk_fall     (sclk_fall),
        .rd_load       (rd_load),
        .pre_last_rise (pre_last_rise),
        .tx_data       (tx_data),
        .tx_avail      (tx_avail),
        .tx_pop        (tx_pop),
        .spi_miso      (spi_miso),
        .spi_req_n     (spi_req_n)
    );

    // Each pop is a single-cycle pulse, because loads are byte-spaced.
    assert_single_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !tx_pop);

endmodule

// File: tb/spi_ctrl_port_bench.sv
// Bench: scoreboard-driven check of the addressed SPI control port.
module spi_ctrl_port_bench;

    localparam int HALF = 8;   // system clocks per serial half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cfg_addr = 7'd0;
    logic       cfg_chk_en = 1'b1;
    logic       spi_csn = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic       spi_req_n;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic [7:0] tx_data = 8'd0;
    logic       tx_avail = 1'b0;
    logic       tx_pop;

    int checks = 0;
    int failures = 0;
    int pops = 0;
    bit done = 0;

    logic [7:0] q_out[$];    // model of the internal outbound queue
    logic [7:0] exp_wr[$];   // scoreboard: expected write bytes

    always #2.5 clk = ~clk;

    spi_ctrl_port u_spi_ctrl_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_addr   (cfg_addr),
        .cfg_chk_en (cfg_chk_en),
        .spi_csn    (spi_csn),
        .spi_sclk   (spi_sclk),
        .spi_mosi   (spi_mosi),
        .spi_miso   (spi_miso),
        .spi_req_n  (spi_req_n),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .tx_data    (tx_data),
        .tx_avail   (tx_avail),
        .tx_pop     (tx_pop)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Queue model: pop on the edge where the design requests it.
    always @(posedge clk) begin
        if (rst_n && tx_pop && q_out.size() != 0) begin
            void'(q_out.pop_front());
            pops++;
        end
    end

    // Queue model: present the head away from the active edge.
    always @(negedge clk) begin
        tx_avail = (q_out.size() != 0);
        tx_data  = (q_out.size() != 0) ? q_out[0] : 8'h00;
    end

    // Monitor: pop and compare every write byte the design delivers.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_wr.size() == 0) begin
                check(0, "R2/R5 unexpected rx_valid (R6)", int'(rx_data), 0);
            end else begin
                logic [7:0] e;
                e = exp_wr.pop_front();
                check(rx_data == e, "R6 write byte", int'(rx_data), int'(e));
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift one byte; nbits bits, optional last falling edge, returns MISO
    // and the request line seen between the seventh rising and falling edges.
    task automatic xfer(input logic [7:0] mo, input int nbits, input bit last_fall,
                        output logic [7:0] mi, output logic req7);
        mi = 8'h00;
        req7 = 1'b0;
        for (int b = 0; b < nbits; b++) begin
            spi_mosi = mo[7-b];
            wait_clk(HALF);
            mi[7-b] = spi_miso;
            spi_sclk = 1'b1;
            wait_clk(HALF);
            if (b == 6) req7 = spi_req_n;
            if (b < nbits - 1 || last_fall) spi_sclk = 1'b0;
        end
    endtask

    task automatic cs_low();
        spi_csn = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_high();
        wait_clk(HALF);
        spi_csn = 1'b1;
        wait_clk(HALF);
        spi_sclk = 1'b0;
        wait_clk(2 * HALF);
    endtask

    // Driver: write transaction of up to three data bytes.
    task automatic send_write(input logic [6:0] a, input int n,
                              input logic [7:0] d0, input logic [7:0] d1,
                              input logic [7:0] d2, input bit hit);
        logic [7:0] d[3];
        logic [7:0] mi;
        logic       r7;
        d[0] = d0; d[1] = d1; d[2] = d2;
        cs_low();
        xfer({a, 1'b0}, 8, 1'b1, mi, r7);
        for (int i = 0; i < n; i++) begin
            if (hit) exp_wr.push_back(d[i]);
            xfer(d[i], 8, 1'b1, mi, r7);
        end
        cs_high();
    endtask

    initial begin
        logic [7:0] mi;
        logic       r7;
        int         p0;

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // Reset state
        check(spi_req_n == 1'b1, "R8 req_n after reset", spi_req_n, 1);
        check(rx_valid == 1'b0, "R5 rx_valid after reset", rx_valid, 0);
        check(spi_miso == 1'b0, "R2 miso idle", spi_miso, 0);

        // R1 R4 R6: three-byte write to address 0
        send_write(7'h00, 3, 8'hA5, 8'h3C, 8'h81, 1'b1);
        check(exp_wr.size() == 0, "R6 all write bytes delivered", exp_wr.size(), 0);

        // R2: mismatching address is ignored
        send_write(7'h12, 2, 8'hFF, 8'h11, 8'h00, 1'b0);

        // R2: moved address is accepted
        cfg_addr = 7'h35;
        send_write(7'h35, 1, 8'h6E, 8'h00, 8'h00, 1'b1);
        send_write(7'h00, 1, 8'h99, 8'h00, 8'h00, 1'b0);
        check(exp_wr.size() == 0, "R2 moved address write delivered", exp_wr.size(), 0);

        // R3: address check disabled
        cfg_chk_en = 1'b0;
        send_write(7'h4B, 2, 8'h10, 8'hEF, 8'h00, 1'b1);
        check(exp_wr.size() == 0, "R3 unchecked address write", exp_wr.size(), 0);
        cfg_chk_en = 1'b1;
        cfg_addr = 7'h00;

        // R11: partial byte discarded, next transaction aligned
        cs_low();
        xfer(8'h00, 8, 1'b1, mi, r7);
        xfer(8'hF0, 5, 1'b1, mi, r7);
        cs_high();
        send_write(7'h00, 1, 8'h5A, 8'h00, 8'h00, 1'b1);
        check(exp_wr.size() == 0, "R11 realigned after partial byte", exp_wr.size(), 0);

        // R5: missing eighth falling edge drops the byte
        cs_low();
        xfer(8'h00, 8, 1'b1, mi, r7);
        xfer(8'hC3, 8, 1'b0, mi, r7);
        cs_high();
        check(exp_wr.size() == 0, "R5 dropped byte gave no strobe", exp_wr.size(), 0);

        // R8: request follows queue when idle
        q_out.push_back(8'hA1);
        q_out.push_back(8'hB2);
        q_out.push_back(8'hC3);
        wait_clk(6);
        check(spi_req_n == 1'b0, "R8 req_n low with data queued", spi_req_n, 0);

        // R7 R9 R10: read three bytes, then one from an empty queue
        p0 = pops;
        cs_low();
        xfer(8'h01, 8, 1'b1, mi, r7);
        xfer(8'h00, 8, 1'b1, mi, r7);
        check(mi == 8'hA1, "R7 read byte 1", mi, 8'hA1);
        check(r7 == 1'b0, "R9 req_n low at byte 1", r7, 0);
        xfer(8'h00, 8, 1'b1, mi, r7);
        check(mi == 8'hB2, "R7 read byte 2", mi, 8'hB2);
        check(r7 == 1'b0, "R9 req_n low at byte 2", r7, 0);
        xfer(8'h00, 8, 1'b1, mi, r7);
        check(mi == 8'hC3, "R4 R7 read byte 3", mi, 8'hC3);
        check(r7 == 1'b1, "R9 req_n high at last byte", r7, 1);
        check(spi_req_n == 1'b1, "R9 req_n held high to byte end", spi_req_n, 1);
        xfer(8'h00, 8, 1'b1, mi, r7);
        check(mi == 8'h00, "R10 empty read returns zero", mi, 0);
        cs_high();
        check(pops - p0 == 3, "R10 pops limited to queued bytes", pops - p0, 3);
        check(spi_req_n == 1'b1, "R8 req_n high when empty", spi_req_n, 1);

        // R2: read to a wrong address shifts zero and does not pop
        q_out.push_back(8'h77);
        wait_clk(6);
        p0 = pops;
        cs_low();
        xfer(8'h0B, 8, 1'b1, mi, r7);
        xfer(8'h00, 8, 1'b1, mi, r7);
        cs_high();
        check(mi == 8'h00, "R2 mismatched read miso", mi, 0);
        check(pops == p0, "R2 mismatched read no pop", pops - p0, 0);
        check(spi_req_n == 1'b0, "R8 req_n low after ignored read", spi_req_n, 0);

        // R3 R7: unchecked read drains the queue
        cfg_chk_en = 1'b0;
        cs_low();
        xfer(8'h55, 8, 1'b1, mi, r7);
        xfer(8'h00, 8, 1'b1, mi, r7);
        cs_high();
        check(mi == 8'h77, "R3 unchecked read byte", mi, 8'h77);
        check(q_out.size() == 0, "R7 queue drained", q_out.size(), 0);

        check(exp_wr.size() == 0, "R6 scoreboard empty", exp_wr.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule